// File: doc/BRIEF.md
# Audio Clock Regeneration Parameter Calculator

This block works out the N and CTS pair that a digital display transmitter needs so that a sink can rebuild the audio sample clock from the pixel clock. A controller pulses `start_i` with a sample rate in Hz, a pixel clock in Hz and a channel count. The engine runs on its own for a few hundred cycles and then pulses `done_o`. At that point it presents N, CTS already aligned for its register, the rate-family code that also picks the register pair, the clock-regeneration packet control word, and the second audio packet control word that carries the layout flag.

The calculation is exact integer arithmetic. The ratio 128·fs : pclk is reduced by its greatest common divisor, which a binary GCD engine finds. Both terms are then scaled by the smallest integer that brings N up to about 128·fs/1000. Doubled and quadrupled rates reuse the register pair of their base family: N is shifted down and the multiple is recorded in the control word. All divisions share one restoring divider that produces one quotient bit per cycle. Both products come from one shift-add multiplier.

The control FSM has these states: IDLE, CHECK, GCD_GO, GCD_WAIT, DN_GO, DN_WAIT, DC_GO, DC_WAIT, DT_GO, DT_WAIT, DM_GO, DM_WAIT, MN_GO, MN_WAIT, MC_GO, MC_WAIT, PACK and FINISH.
- IDLE goes to CHECK on `start_i`.
- CHECK goes to FINISH when the rate or the pixel clock is zero, and to GCD_GO otherwise.
- Each *_GO state launches one unit and moves to its *_WAIT state.
- Each *_WAIT state holds until that unit signals completion, then moves on in the order GCD, reduced N, reduced CTS, target, multiplier, final N, final CTS.
- After the last wait the FSM passes through PACK and then FINISH, and returns to IDLE.

Top module: `aud_regen_calc`

## Requirements
- R1: With a channel count of 0, the sample rate input is ignored and the engine uses 48000 Hz with 2 channels, so the layout flag is 0.
- R2: With g = gcd(128·fs, pclk), Nr = 128·fs/g and Cr = pclk/g, the multiplier is m = (floor(128·fs/1000) + Nr − 1) / Nr in integer division. N = Nr·m and CTS = Cr·m, each truncated to 32 bits.
- R3: For 88200 and 96000 Hz, `n_o` is N shifted right by 1 and the multiple is 2. For 176400 and 192000 Hz, `n_o` is N shifted right by 2 and the multiple is 4. Every other rate has a multiple of 1 and an unshifted N.
- R4: `fam_o` is 2 for 44100, 88200 and 176400 Hz, and 3 for 48000, 96000 and 192000 Hz. It is 1 for 32000 Hz and for any other nonzero rate.
- R5: `cts_o` is CTS shifted left by 12 bits and truncated to 32 bits.
- R6: `acr_ctl_o` has bits 31, 8, 1 and 0 set, the multiple in bits 18:16 and the family code in bits 5:4. All other bits are 0.
- R7: `aud_ctl2_o` bit 0 is 1. Bit 1 is 0 for exactly 2 channels and 1 for any other nonzero count.
- R8: A rate of 0 (with a nonzero channel count) or a pixel clock of 0 completes with `err_o` = 1 and every result output at 0.
- R9: `busy_o` rises in the cycle after an accepted start and stays high through the `done_o` cycle. `done_o` lasts one cycle. A start seen while busy is ignored.
- R10: After reset all outputs are 0. Results hold unchanged from `done_o` until the next accepted start produces new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| fs_hz_i | input | FS_W | Audio sample rate in Hz |
| pclk_hz_i | input | DW | Pixel clock in Hz |
| chan_i | input | CH_W | Channel count, 0 selects defaults |
| busy_o | output | 1 | Calculation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Zero rate or zero pixel clock seen |
| n_o | output | DW | N after family folding |
| cts_o | output | DW | CTS aligned for its register (shifted by 12) |
| fam_o | output | 2 | Rate family code and register pair select |
| acr_ctl_o | output | 32 | Clock-regeneration packet control word |
| aud_ctl2_o | output | 2 | Second audio packet control word (layout, enable) |

## Verification
The bench sweeps every folded rate, several rates outside the families, and tiny rates where the multiplier comes out as zero. It pairs them with pixel clocks that share large, small and no common factors, and checks each result against arithmetic done in the bench.
- A wrong GCD or a missing ceiling term shows up as an N/CTS pair with the right ratio but the wrong scale.
- A misclassified rate shows up as a wrong family code, a wrong multiple or an unshifted N.
- The bench also drives zero operands, the default path for a zero channel count, and a second start issued mid-run. A design that accepted that start would return the second operand set's result in place of the first.

// File: rtl/aud_regen_pkg.sv
package aud_regen_pkg;

    typedef enum logic [1:0] {
        FAM_NONE = 2'd0,
        FAM_32K  = 2'd1,
        FAM_44K1 = 2'd2,
        FAM_48K  = 2'd3
    } fam_e;

    typedef struct packed {
        fam_e       fam;
        logic [2:0] mult;
        logic [1:0] shamt;
    } rate_class_t;

    localparam int unsigned DEFAULT_FS_HZ = 48000;
    localparam int unsigned TARGET_DIV    = 1000;
    localparam int unsigned FS_SCALE_SH   = 7;
    localparam int unsigned CTS_ALIGN_SH  = 12;

    function automatic rate_class_t classify_rate(input logic [31:0] fs);
        rate_class_t c;
        c.fam   = FAM_32K;
        c.mult  = 3'd1;
        c.shamt = 2'd0;
        case (fs)
            32'd44100:  c.fam = FAM_44K1;
            32'd48000:  c.fam = FAM_48K;
            32'd88200:  begin c.fam = FAM_44K1; c.mult = 3'd2; c.shamt = 2'd1; end
            32'd96000:  begin c.fam = FAM_48K;  c.mult = 3'd2; c.shamt = 2'd1; end
            32'd176400: begin c.fam = FAM_44K1; c.mult = 3'd4; c.shamt = 2'd2; end
            32'd192000: begin c.fam = FAM_48K;  c.mult = 3'd4; c.shamt = 2'd2; end
            default:    ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/aud_regen_gcd.sv
module aud_regen_gcd #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    output logic          done_o,
    output logic [DW-1:0] gcd_o
);
    localparam int KW = $clog2(DW + 1);

    typedef enum logic [1:0] {G_IDLE, G_ALIGN, G_LOOP} gstate_e;

    gstate_e       st_r;
    logic [DW-1:0] a_r, b_r;
    logic [KW-1:0] k_r;

    // Binary method: strip common twos, then shift/subtract until equal.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_r   <= G_IDLE;
            a_r    <= '0;
            b_r    <= '0;
            k_r    <= '0;
            done_o <= 1'b0;
            gcd_o  <= '0;
        end else begin
            done_o <= 1'b0;
            if (start_i) begin
                a_r  <= a_i;
                b_r  <= b_i;
                k_r  <= '0;
                st_r <= G_ALIGN;
            end else begin
                unique case (st_r)
                    G_IDLE: ;
                    G_ALIGN: begin
                        if (!a_r[0] && !b_r[0]) begin
                            a_r <= a_r >> 1;
                            b_r <= b_r >> 1;
                            k_r <= k_r + KW'(1);
                        end else begin
                            st_r <= G_LOOP;
                        end
                    end
                    G_LOOP: begin
                        if (a_r == b_r) begin
                            gcd_o  <= a_r << k_r;
                            done_o <= 1'b1;
                            st_r   <= G_IDLE;
                        end else if (!a_r[0]) begin
                            a_r <= a_r >> 1;
                        end else if (!b_r[0]) begin
                            b_r <= b_r >> 1;
                        end else if (a_r > b_r) begin
                            a_r <= a_r - b_r;
                        end else begin
                            b_r <= b_r - a_r;
                        end
                    end
                    default: st_r <= G_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/aud_regen_div.sv
module aud_regen_div #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [DW-1:0] dvd_i,
    input  logic [DW-1:0] dvs_i,
    output logic          done_o,
    output logic [DW-1:0] quo_o
);
    localparam int CW = $clog2(DW + 1);

    logic [DW-1:0] rem_r, dvs_r;
    logic [CW-1:0] cnt_r;
    logic          run_r;
    logic [DW:0]   shifted, trial;
    logic          fits;

    always_comb begin
        shifted = {rem_r, quo_o[DW-1]};
        trial   = shifted - {1'b0, dvs_r};
        fits    = !trial[DW];
    end

    // Restoring division, one quotient bit per cycle, DW cycles.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_r  <= '0;
            dvs_r  <= '0;
            cnt_r  <= '0;
            run_r  <= 1'b0;
            done_o <= 1'b0;
            quo_o  <= '0;
        end else begin
            done_o <= 1'b0;
            if (start_i) begin
                quo_o <= dvd_i;
                rem_r <= '0;
                dvs_r <= dvs_i;
                cnt_r <= CW'(DW);
                run_r <= 1'b1;
            end else if (run_r) begin
                rem_r <= fits ? trial[DW-1:0] : shifted[DW-1:0];
                quo_o <= {quo_o[DW-2:0], fits};
                cnt_r <= cnt_r - CW'(1);
                if (cnt_r == CW'(1)) begin
                    run_r  <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/aud_regen_mul.sv
module aud_regen_mul #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    output logic          done_o,
    output logic [DW-1:0] prod_o
);
    localparam int CW = $clog2(DW + 1);

    logic [DW-1:0] mc_r, mp_r;
    logic [CW-1:0] cnt_r;
    logic          run_r;

    // Shift-add multiply keeping the low DW bits of the product.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mc_r   <= '0;
            mp_r   <= '0;
            cnt_r  <= '0;
            run_r  <= 1'b0;
            done_o <= 1'b0;
            prod_o <= '0;
        end else begin
            done_o <= 1'b0;
            if (start_i) begin
                prod_o <= '0;
                mc_r   <= a_i;
                mp_r   <= b_i;
                cnt_r  <= CW'(DW);
                run_r  <= 1'b1;
            end else if (run_r) begin
                if (mp_r[0]) prod_o <= prod_o + mc_r;
                mc_r  <= mc_r << 1;
                mp_r  <= mp_r >> 1;
                cnt_r <= cnt_r - CW'(1);
                if (cnt_r == CW'(1)) begin
                    run_r  <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/aud_regen_calc.sv
module aud_regen_calc
    import aud_regen_pkg::*;
#(
    parameter int FS_W = 18,
    parameter int DW   = 32,
    parameter int CH_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [FS_W-1:0] fs_hz_i,
    input  logic [DW-1:0]   pclk_hz_i,
    input  logic [CH_W-1:0] chan_i,
    output logic            busy_o,
    output logic            done_o,
    output logic            err_o,
    output logic [DW-1:0]   n_o,
    output logic [DW-1:0]   cts_o,
    output logic [1:0]      fam_o,
    output logic [31:0]     acr_ctl_o,
    output logic [1:0]      aud_ctl2_o
);
    localparam logic [CH_W-1:0] STEREO = CH_W'(2);

    typedef enum logic [4:0] {
        S_IDLE, S_CHECK,
        S_GCD_GO, S_GCD_WAIT,
        S_DN_GO, S_DN_WAIT,
        S_DC_GO, S_DC_WAIT,
        S_DT_GO, S_DT_WAIT,
        S_DM_GO, S_DM_WAIT,
        S_MN_GO, S_MN_WAIT,
        S_MC_GO, S_MC_WAIT,
        S_PACK, S_FINISH
    } state_e;

    state_e        state_r, state_n;
    logic [DW-1:0] fs_r, pclk_r, g_r, nred_r, cred_r, t_r, mul_r, nfin_r, cfin_r;
    logic          wide_r;
    logic [DW-1:0] n0_w;
    logic          bad_w;

    logic          gcd_done, div_done, mul_done, div_start, mul_start;
    logic [DW-1:0] gcd_res, div_q, mul_p;
    logic [DW-1:0] div_a, div_b, mul_a, mul_b;

    rate_class_t   pack_cls;
    logic [31:0]   pack_ctl;

    assign n0_w   = fs_r << FS_SCALE_SH;
    assign bad_w  = (fs_r == '0) || (pclk_r == '0);
    assign busy_o = (state_r != S_IDLE);

    // Operand steering for the shared divider and multiplier.
    always_comb begin
        div_start = 1'b0;
        div_a     = '0;
        div_b     = DW'(1);
        mul_start = 1'b0;
        mul_a     = '0;
        mul_b     = '0;
        unique case (state_r)
            S_DN_GO: begin div_start = 1'b1; div_a = n0_w;   div_b = g_r; end
            S_DC_GO: begin div_start = 1'b1; div_a = pclk_r; div_b = g_r; end
            S_DT_GO: begin div_start = 1'b1; div_a = n0_w;   div_b = DW'(TARGET_DIV); end
            S_DM_GO: begin
                div_start = 1'b1;
                div_a     = t_r + nred_r - DW'(1);
                div_b     = nred_r;
            end
            S_MN_GO: begin mul_start = 1'b1; mul_a = nred_r; mul_b = mul_r; end
            S_MC_GO: begin mul_start = 1'b1; mul_a = cred_r; mul_b = mul_r; end
            default: ;
        endcase
    end

    aud_regen_gcd #(.DW(DW)) u_gcd (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (state_r == S_GCD_GO),
        .a_i     (n0_w),
        .b_i     (pclk_r),
        .done_o  (gcd_done),
        .gcd_o   (gcd_res)
    );

    aud_regen_div #(.DW(DW)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (div_start),
        .dvd_i   (div_a),
        .dvs_i   (div_b),
        .done_o  (div_done),
        .quo_o   (div_q)
    );

    aud_regen_mul #(.DW(DW)) u_mul (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (mul_start),
        .a_i     (mul_a),
        .b_i     (mul_b),
        .done_o  (mul_done),
        .prod_o  (mul_p)
    );

    // Classification and control-word packing.
    always_comb begin
        pack_cls        = classify_rate(32'(fs_r));
        pack_ctl        = '0;
        pack_ctl[31]    = 1'b1;
        pack_ctl[8]     = 1'b1;
        pack_ctl[18:16] = pack_cls.mult;
        pack_ctl[5:4]   = pack_cls.fam;
        pack_ctl[1:0]   = 2'b11;
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_r <= S_IDLE;
        else        state_r <= state_n;
    end

    // Next-state logic.
    always_comb begin
        state_n = state_r;
        unique case (state_r)
            S_IDLE:     if (start_i) state_n = S_CHECK;
            S_CHECK:    state_n = bad_w ? S_FINISH : S_GCD_GO;
            S_GCD_GO:   state_n = S_GCD_WAIT;
            S_GCD_WAIT: if (gcd_done) state_n = S_DN_GO;
            S_DN_GO:    state_n = S_DN_WAIT;
            S_DN_WAIT:  if (div_done) state_n = S_DC_GO;
            S_DC_GO:    state_n = S_DC_WAIT;
            S_DC_WAIT:  if (div_done) state_n = S_DT_GO;
            S_DT_GO:    state_n = S_DT_WAIT;
            S_DT_WAIT:  if (div_done) state_n = S_DM_GO;
            S_DM_GO:    state_n = S_DM_WAIT;
            S_DM_WAIT:  if (div_done) state_n = S_MN_GO;
            S_MN_GO:    state_n = S_MN_WAIT;
            S_MN_WAIT:  if (mul_done) state_n = S_MC_GO;
            S_MC_GO:    state_n = S_MC_WAIT;
            S_MC_WAIT:  if (mul_done) state_n = S_PACK;
            S_PACK:     state_n = S_FINISH;
            S_FINISH:   state_n = S_IDLE;
            default:    state_n = S_IDLE;
        endcase
    end

    // Datapath and outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_r       <= '0;
            pclk_r     <= '0;
            wide_r     <= 1'b0;
            g_r        <= '0;
            nred_r     <= '0;
            cred_r     <= '0;
            t_r        <= '0;
            mul_r      <= '0;
            nfin_r     <= '0;
            cfin_r     <= '0;
            done_o     <= 1'b0;
            err_o      <= 1'b0;
            n_o        <= '0;
            cts_o      <= '0;
            fam_o      <= '0;
            acr_ctl_o  <= '0;
            aud_ctl2_o <= '0;
        end else begin
            done_o <= 1'b0;
            unique case (state_r)
                S_IDLE: begin
                    if (start_i) begin
                        pclk_r <= pclk_hz_i;
                        if (chan_i == '0) begin
                            fs_r   <= DW'(DEFAULT_FS_HZ);
                            wide_r <= 1'b0;
                        end else begin
                            fs_r   <= DW'(fs_hz_i);
                            wide_r <= (chan_i != STEREO);
                        end
                    end
                end
                S_CHECK: begin
                    err_o <= bad_w;
                    if (bad_w) begin
                        done_o     <= 1'b1;
                        n_o        <= '0;
                        cts_o      <= '0;
                        fam_o      <= '0;
                        acr_ctl_o  <= '0;
                        aud_ctl2_o <= '0;
                    end
                end
                S_GCD_WAIT: if (gcd_done) g_r    <= gcd_res;
                S_DN_WAIT:  if (div_done) nred_r <= div_q;
                S_DC_WAIT:  if (div_done) cred_r <= div_q;
                S_DT_WAIT:  if (div_done) t_r    <= div_q;
                S_DM_WAIT:  if (div_done) mul_r  <= div_q;
                S_MN_WAIT:  if (mul_done) nfin_r <= mul_p;
                S_MC_WAIT:  if (mul_done) cfin_r <= mul_p;
                S_PACK: begin
                    done_o     <= 1'b1;
                    n_o        <= nfin_r >> pack_cls.shamt;
                    cts_o      <= cfin_r << CTS_ALIGN_SH;
                    fam_o      <= pack_cls.fam;
                    acr_ctl_o  <= pack_ctl;
                    aud_ctl2_o <= {wide_r, 1'b1};
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/aud_regen_calc_chk.sv
module aud_regen_calc_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          busy_o,
    input logic          done_o,
    input logic          err_o,
    input logic [DW-1:0] n_o,
    input logic [DW-1:0] cts_o,
    input logic [1:0]    fam_o,
    input logic [31:0]   acr_ctl_o,
    input logic [1:0]    aud_ctl2_o
);
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && !busy_o);

    p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);

    p_err_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o) |-> (n_o == '0 && cts_o == '0 && fam_o == 2'd0
                               && acr_ctl_o == '0 && aud_ctl2_o == 2'd0));

    p_ctl_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> (acr_ctl_o[31] && acr_ctl_o[8]
                                && acr_ctl_o[1:0] == 2'b11 && acr_ctl_o[5:4] == fam_o));

    p_mult_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> $countones(acr_ctl_o[18:16]) == 1);

    p_fam_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> fam_o != 2'd0);

    p_cts_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> cts_o[11:0] == 12'd0);

    p_layout_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> aud_ctl2_o[0]);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> ($stable(n_o) && $stable(cts_o) && $stable(acr_ctl_o)
                     && $stable(fam_o) && $stable(aud_ctl2_o)));
endmodule

bind aud_regen_calc aud_regen_calc_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .n_o        (n_o),
    .cts_o      (cts_o),
    .fam_o      (fam_o),
    .acr_ctl_o  (acr_ctl_o),
    .aud_ctl2_o (aud_ctl2_o)
);

// File: tb/aud_regen_calc_bench.sv
module aud_regen_calc_bench;
    localparam int FS_W = 18;
    localparam int DW   = 32;
    localparam int CH_W = 4;
    localparam longint M32 = 64'hFFFF_FFFF;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic [FS_W-1:0] fs_hz_i = '0;
    logic [DW-1:0]   pclk_hz_i = '0;
    logic [CH_W-1:0] chan_i = '0;
    logic            busy_o, done_o, err_o;
    logic [DW-1:0]   n_o, cts_o;
    logic [1:0]      fam_o;
    logic [31:0]     acr_ctl_o;
    logic [1:0]      aud_ctl2_o;

    int n_checks = 0;
    int n_fail   = 0;

    longint e_n, e_cts, e_ctl, e_fam, e_lay, e_err;

    always #10 clk = ~clk;

    aud_regen_calc #(.FS_W(FS_W), .DW(DW), .CH_W(CH_W)) u_aud_regen_calc (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .fs_hz_i(fs_hz_i),
        .pclk_hz_i(pclk_hz_i), .chan_i(chan_i), .busy_o(busy_o), .done_o(done_o),
        .err_o(err_o), .n_o(n_o), .cts_o(cts_o), .fam_o(fam_o),
        .acr_ctl_o(acr_ctl_o), .aud_ctl2_o(aud_ctl2_o)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic longint euclid(input longint a, input longint b);
        longint x = a, y = b, t;
        while (y != 0) begin t = x % y; x = y; y = t; end
        return x;
    endfunction

    task automatic compute(input longint fs_in, input longint pclk, input int ch);
        longint fs, n, c, g, m, mult, sh, fam;
        bit wide;
        fs   = (ch == 0) ? 48000 : fs_in;
        wide = (ch == 0) ? 1'b0 : (ch != 2);
        if (fs == 0 || pclk == 0) begin
            e_err = 1; e_n = 0; e_cts = 0; e_ctl = 0; e_fam = 0; e_lay = 0;
            return;
        end
        n = (128 * fs) & M32;
        c = pclk;
        g = euclid(n, c);
        n = n / g;
        c = c / g;
        m = ((128 * fs / 1000) + n - 1) / n;
        n = (n * m) & M32;
        c = (c * m) & M32;
        fam = 1; mult = 1; sh = 0;
        if (fs == 44100 || fs == 88200 || fs == 176400) fam = 2;
        if (fs == 48000 || fs == 96000 || fs == 192000) fam = 3;
        if (fs == 88200 || fs == 96000) begin mult = 2; sh = 1; end
        if (fs == 176400 || fs == 192000) begin mult = 4; sh = 2; end
        e_err = 0;
        e_n   = n >> sh;
        e_cts = (c << 12) & M32;
        e_fam = fam;
        e_ctl = (longint'(1) << 31) | (1 << 8) | (mult << 16) | (fam << 4) | 3;
        e_lay = wide ? 3 : 1;
    endtask

    task automatic wait_done();
        int k = 0;
        while (!done_o && k < 4000) begin @(negedge clk); k++; end
        if (!done_o) check("R9 done timeout", 0, 1);
    endtask

    task automatic launch(input longint fs, input longint pclk, input int ch);
        @(negedge clk);
        fs_hz_i   = FS_W'(fs);
        pclk_hz_i = DW'(pclk);
        chan_i    = CH_W'(ch);
        start_i   = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R9 busy after start", longint'(busy_o), 1);
    endtask

    task automatic compare_all(input int ch);
        check("R2 R3 n", longint'(n_o), e_n);
        check("R2 R5 cts", longint'(cts_o), e_cts);
        check("R6 ctl", longint'(acr_ctl_o), e_ctl);
        check("R4 fam", longint'(fam_o), e_fam);
        check(ch == 0 ? "R1 layout" : "R7 layout", longint'(aud_ctl2_o), e_lay);
        check("R8 err", longint'(err_o), e_err);
    endtask

    task automatic run(input longint fs, input longint pclk, input int ch);
        compute(fs, pclk, ch);
        launch(fs, pclk, ch);
        wait_done();
        compare_all(ch);
        @(negedge clk);
        check("R9 done one cycle", longint'(done_o), 0);
        check("R9 idle after done", longint'(busy_o), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        longint rates [11] = '{32000, 44100, 48000, 88200, 96000, 176400, 192000,
                               22050, 8000, 1, 7};
        longint clks [6]   = '{25200000, 74250000, 148500000, 27000000, 594000000, 999};
        int     chs [4]    = '{2, 0, 6, 3};

        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 reset busy", longint'(busy_o), 0);
        check("R10 reset done", longint'(done_o), 0);
        check("R10 reset n", longint'(n_o), 0);
        check("R10 reset ctl", longint'(acr_ctl_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < 11; i++)
            for (int j = 0; j < 6; j++)
                run(rates[i], clks[j], chs[(i + j) % 4]);

        // R1: zero channel count ignores the rate input
        run(44100, 74250000, 0);
        run(0, 74250000, 0);
        // R7: eight channels set the layout flag
        run(48000, 148500000, 8);
        // R8: zero operands
        run(0, 74250000, 2);
        run(48000, 0, 2);
        run(48000, 0, 0);

        // R9: a start while busy is ignored
        compute(96000, 74250000, 2);
        launch(96000, 74250000, 2);
        repeat (10) @(negedge clk);
        fs_hz_i = FS_W'(44100); pclk_hz_i = DW'(27000000); chan_i = CH_W'(6);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done();
        check("R9 ignored start n", longint'(n_o), e_n);
        check("R9 ignored start ctl", longint'(acr_ctl_o), e_ctl);
        check("R9 ignored start layout", longint'(aud_ctl2_o), e_lay);

        // R10: results hold while idle
        repeat (8) @(negedge clk);
        check("R10 hold n", longint'(n_o), e_n);
        check("R10 hold cts", longint'(cts_o), e_cts);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule